// File: doc/BRIEF.md
# Debug Register Write Handler

This block sits behind the word-level side of a serial debug link and handles one kind of command: a 32-bit write into a small file of debug registers. Each 16-bit word that arrives is presented with a one-cycle valid pulse. A write is made of three transfers: a command word that names the target register, then the upper operand half, then the lower operand half. Every transfer loads a 17-bit reply. The host shifts that reply out during the next transfer, so the answer to a word always arrives one transfer later.

Any command word outside the write pattern is rejected with an illegal reply, and the block goes back to waiting for a command. A second write port serves the on-chip supervisor. It is granted only while the serial clock is idle, and it always yields to a serial write that wants the register file in the same cycle. The register file has a registered read port for on-chip consumers. It also keeps a dedicated copy of the status register, which is driven onto its own output.

Top module: `dbg_wr_handler`

## Requirements
- R1: A word taken while waiting for a command is a write command when bits 15:12 are 4'h2, bits 11:8 are 4'hC and bits 7:5 are 3'b100. Bits 4:0 give the target index. The reply loaded for this word is the not-ready code 17'h10000, and the block then waits for operand data.
- R2: The first operand word after a write command supplies data bits 31:16 and the second supplies bits 15:0. The reply loaded for the first operand word is 17'h10000.
- R3: The reply loaded for the second operand word is the complete code 17'h0FFFF. One clock after that reply appears, rf_we is high for exactly one cycle, carrying the target index on rf_idx and the assembled 32-bit value on rf_wdata.
- R4: A completed write replaces all 32 bits of the target register. Earlier contents do not survive in any bit, and the value can be read back through rd_idx/rd_data with one cycle of read latency.
- R5: A command word that does not match the write pattern loads the illegal code 17'h1FFFF. It causes no register write, and the next word is again decoded as a command.
- R6: status_reg always holds the last value written to register index 0 (the status register), whichever port wrote it.
- R7: An internal write request (cpu_wr_req) is granted only in a cycle where sclk_idle is high. While sclk_idle is low, cpu_wr_ack stays low and the register file is not written.
- R8: When a serial write and a granted internal write compete in the same cycle, the serial write goes to the register file first. The internal write is acknowledged and performed one cycle later.
- R9: Synchronous reset returns the block to waiting for a command, with the reply at 17'h10000, rf_we and cpu_wr_ack low, and every debug register (including status_reg) reading as zero.
- R10: The reply output changes only on a cycle in which a word is taken. Between transfers it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_valid | input | 1 | One-cycle pulse marking a received link word |
| link_word | input | 16 | Received link word |
| reply_word | output | 17 | Reply to be shifted out on the next transfer |
| sclk_idle | input | 1 | High while the serial clock is idle |
| cpu_wr_req | input | 1 | Internal write request, held until acknowledged |
| cpu_wr_idx | input | 5 | Internal write target index |
| cpu_wr_data | input | 32 | Internal write data |
| cpu_wr_ack | output | 1 | One-cycle pulse: internal write performed |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 32 | Read port data, one cycle after rd_idx |
| status_reg | output | 32 | Current status register contents |

## Verification
The assertions run on every cycle. They check how a command word maps to its reply (accepted or illegal), that the complete reply coincides with the serial write request, that serial writes take precedence over internal ones, that no internal write is granted while the serial clock runs, that the status copy tracks writes to index 0, and the post-reset state. Some behaviour only the bench scenarios can show. These are the ordering of the two operand halves in the stored value, the full 32-bit overwrite of an earlier value, the zero read of registers never written after a reset, and the clean restart when reset lands in the middle of a command sequence.

// File: rtl/dbg_wr_pkg.sv
package dbg_wr_pkg;
  localparam int WORD_W  = 16;
  localparam int DATA_W  = 2 * WORD_W;
  localparam int REPLY_W = WORD_W + 1;

  localparam logic [REPLY_W-1:0] RPL_NOT_READY = 17'h10000;
  localparam logic [REPLY_W-1:0] RPL_ILLEGAL   = 17'h1FFFF;
  localparam logic [REPLY_W-1:0] RPL_COMPLETE  = 17'h0FFFF;

  localparam logic [3:0] OPC_GROUP = 4'h2;
  localparam logic [3:0] OPC_KIND  = 4'hC;
  localparam logic [2:0] OPC_SUB   = 3'b100;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_MSW = 2'd1,
    ST_LSW = 2'd2
  } seq_state_e;

  function automatic logic is_wr_cmd(input logic [WORD_W-1:0] w);
    return (w[15:12] == OPC_GROUP) && (w[11:8] == OPC_KIND) && (w[7:5] == OPC_SUB);
  endfunction
endpackage

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_wr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_valid,
  input  logic [WORD_W-1:0]  link_word,
  output logic [REPLY_W-1:0] reply_word,
  output logic               ser_req,
  output logic [IDX_W-1:0]   ser_idx,
  output logic [DATA_W-1:0]  ser_data
);
  seq_state_e         state_q;
  logic [REPLY_W-1:0] reply_q;
  logic [WORD_W-1:0]  hi_q;
  logic               cmd_hit;

  assign cmd_hit    = is_wr_cmd(link_word);
  assign reply_word = reply_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_CMD;
      reply_q  <= RPL_NOT_READY;
      hi_q     <= '0;
      ser_req  <= 1'b0;
      ser_idx  <= '0;
      ser_data <= '0;
    end else begin
      ser_req <= 1'b0;
      if (link_valid) begin
        unique case (state_q)
          ST_CMD: begin
            if (cmd_hit) begin
              ser_idx <= link_word[IDX_W-1:0];
              state_q <= ST_MSW;
              reply_q <= RPL_NOT_READY;
            end else begin
              reply_q <= RPL_ILLEGAL;
            end
          end
          ST_MSW: begin
            hi_q    <= link_word;
            state_q <= ST_LSW;
            reply_q <= RPL_NOT_READY;
          end
          ST_LSW: begin
            ser_data <= {hi_q, link_word};
            ser_req  <= 1'b1;
            reply_q  <= RPL_COMPLETE;
            state_q  <= ST_CMD;
          end
          default: state_q <= ST_CMD;
        endcase
      end
    end
  end

  assert_cmd_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (link_valid && state_q == ST_CMD && cmd_hit) |=> (reply_q == RPL_NOT_READY && state_q == ST_MSW));

  assert_msw_reply_R2: assert property (@(posedge clk) disable iff (rst)
    (link_valid && state_q == ST_MSW) |=> (reply_q == RPL_NOT_READY && state_q == ST_LSW));

  assert_done_reply_R3: assert property (@(posedge clk) disable iff (rst)
    ser_req |-> (reply_q == RPL_COMPLETE));

  assert_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    (link_valid && state_q == ST_CMD && !cmd_hit) |=> (reply_q == RPL_ILLEGAL && !ser_req && state_q == ST_CMD));

  assert_reply_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !link_valid |=> $stable(reply_q));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (reply_q == RPL_NOT_READY && state_q == ST_CMD && !ser_req));
endmodule

// File: rtl/dbg_wr_arb.sv
module dbg_wr_arb #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_req,
  input  logic [IDX_W-1:0]  ser_idx,
  input  logic [DATA_W-1:0] ser_data,
  input  logic              sclk_idle,
  input  logic              cpu_req,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              cpu_ack,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_data
);
  logic cpu_ok;

  assign cpu_ok = cpu_req && sclk_idle && !ser_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we   <= 1'b0;
      cpu_ack <= 1'b0;
      rf_idx  <= '0;
      rf_data <= '0;
    end else begin
      rf_we   <= ser_req || cpu_ok;
      cpu_ack <= cpu_ok;
      if (ser_req) begin
        rf_idx  <= ser_idx;
        rf_data <= ser_data;
      end else if (cpu_ok) begin
        rf_idx  <= cpu_idx;
        rf_data <= cpu_data;
      end
    end
  end

  assert_serial_first_R8: assert property (@(posedge clk) disable iff (rst)
    ser_req |=> (rf_we && !cpu_ack && rf_idx == $past(ser_idx) && rf_data == $past(ser_data)));

  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_req && !cpu_req) |=> ##1 (rf_we == $past(cpu_ok)));

  assert_idle_gate_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> ($past(sclk_idle) && $past(cpu_req) && rf_we));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!rf_we && !cpu_ack));
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile #(
  parameter int NUM_REGS   = 32,
  parameter int DATA_W     = 32,
  parameter int STATUS_IDX = 0,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0]   mem [NUM_REGS];
  logic [DATA_W-1:0]   mem_rd_q;
  logic [NUM_REGS-1:0] valid_q;
  logic                vld_rd_q;
  logic                hit_status;

  assign hit_status = we && (widx == IDX_W'(STATUS_IDX));
  assign rdata      = vld_rd_q ? mem_rd_q : '0;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    mem_rd_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      vld_rd_q <= 1'b0;
      status   <= '0;
    end else begin
      vld_rd_q <= valid_q[ridx];
      if (we) valid_q[widx] <= 1'b1;
      if (hit_status) status <= wdata;
    end
  end

  assert_status_copy_R6: assert property (@(posedge clk) disable iff (rst)
    hit_status |=> (status == $past(wdata)));

  assert_status_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !hit_status |=> $stable(status));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (valid_q == '0 && status == '0));
endmodule

// File: rtl/dbg_wr_handler.sv
module dbg_wr_handler
  import dbg_wr_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int STATUS_IDX = 0,
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_valid,
  input  logic [WORD_W-1:0]  link_word,
  output logic [REPLY_W-1:0] reply_word,
  input  logic               sclk_idle,
  input  logic               cpu_wr_req,
  input  logic [IDX_W-1:0]   cpu_wr_idx,
  input  logic [DATA_W-1:0]  cpu_wr_data,
  output logic               cpu_wr_ack,
  output logic               rf_we,
  output logic [IDX_W-1:0]   rf_idx,
  output logic [DATA_W-1:0]  rf_wdata,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic [DATA_W-1:0]  status_reg
);
  logic              ser_req;
  logic [IDX_W-1:0]  ser_idx;
  logic [DATA_W-1:0] ser_data;

  dbg_cmd_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .link_valid (link_valid),
    .link_word  (link_word),
    .reply_word (reply_word),
    .ser_req    (ser_req),
    .ser_idx    (ser_idx),
    .ser_data   (ser_data)
  );

  dbg_wr_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .ser_req   (ser_req),
    .ser_idx   (ser_idx),
    .ser_data  (ser_data),
    .sclk_idle (sclk_idle),
    .cpu_req   (cpu_wr_req),
    .cpu_idx   (cpu_wr_idx),
    .cpu_data  (cpu_wr_data),
    .cpu_ack   (cpu_wr_ack),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .rf_data   (rf_wdata)
  );

  dbg_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .STATUS_IDX(STATUS_IDX)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .widx   (rf_idx),
    .wdata  (rf_wdata),
    .ridx   (rd_idx),
    .rdata  (rd_data),
    .status (status_reg)
  );
endmodule

// File: tb/dbg_wr_handler_tb_top.sv
`timescale 1ns/1ps
module dbg_wr_handler_tb_top;
  localparam logic [16:0] NR   = 17'h10000;
  localparam logic [16:0] ILL  = 17'h1FFFF;
  localparam logic [16:0] COMP = 17'h0FFFF;
  localparam int NVEC = 16;
  // each entry: {link word, expected reply after that word}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h2C83, NR},   {16'hDEAD, NR},   {16'hBEEF, COMP},
    {16'h2D00, ILL},  {16'h2C03, ILL},  {16'h3C80, ILL},  {16'h2CE0, ILL},
    {16'h2C80, NR},   {16'h1234, NR},   {16'h5678, COMP},
    {16'h2C9F, NR},   {16'hFFFF, NR},   {16'h0000, COMP},
    {16'h2C83, NR},   {16'h0000, NR},   {16'h0001, COMP}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_valid = 1'b0;
  logic [15:0] link_word = '0;
  logic [16:0] reply_word;
  logic        sclk_idle = 1'b0;
  logic        cpu_wr_req = 1'b0;
  logic [4:0]  cpu_wr_idx = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        cpu_wr_ack;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [31:0] status_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dbg_wr_handler dut_i (
    .clk(clk), .rst(rst), .link_valid(link_valid), .link_word(link_word),
    .reply_word(reply_word), .sclk_idle(sclk_idle), .cpu_wr_req(cpu_wr_req),
    .cpu_wr_idx(cpu_wr_idx), .cpu_wr_data(cpu_wr_data), .cpu_wr_ack(cpu_wr_ack),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rd_idx(rd_idx),
    .rd_data(rd_data), .status_reg(status_reg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    link_valid = 1'b1;
    link_word  = w;
    @(negedge clk);
    link_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [4:0] i, output logic [31:0] v);
    @(negedge clk);
    rd_idx = i;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R9: state right after reset
    check("R9 reply", 32'(reply_word), 32'(NR));
    check("R9 rf_we", 32'(rf_we), 0);
    check("R9 ack", 32'(cpu_wr_ack), 0);
    check("R9 status", status_reg, 0);

    for (int k = 0; k < NVEC; k++) begin
      string tag;
      send_word(VEC[k][32:17]);
      tag = (VEC[k][16:0] == ILL) ? "R5" : (VEC[k][16:0] == COMP) ? "R3" : "R1/R2";
      check($sformatf("%s vec%0d", tag, k), 32'(reply_word), 32'(VEC[k][16:0]));
    end

    read_reg(5'd3, v);  check("R4 overwrite reg3", v, 32'h0000_0001);
    read_reg(5'd31, v); check("R4 halves reg31", v, 32'hFFFF_0000);
    read_reg(5'd0, v);  check("R4 reg0", v, 32'h1234_5678);
    check("R6 status", status_reg, 32'h1234_5678);
    read_reg(5'd5, v);  check("R9 unwritten reg5", v, 0);

    // R3: strobe timing and content
    send_word(16'h2C87);
    send_word(16'hA5A5);
    send_word(16'h5A5A);
    check("R3 strobe early", 32'(rf_we), 0);
    @(negedge clk);
    check("R3 strobe", 32'(rf_we), 1);
    check("R3 idx", 32'(rf_idx), 7);
    check("R3 data", rf_wdata, 32'hA5A5_5A5A);
    @(negedge clk);
    check("R3 strobe one cycle", 32'(rf_we), 0);
    // R10: reply holds between transfers
    repeat (3) @(negedge clk);
    check("R10 hold", 32'(reply_word), 32'(COMP));

    // R7: no internal write while serial clock runs
    sclk_idle   = 1'b0;
    cpu_wr_req  = 1'b1;
    cpu_wr_idx  = 5'd4;
    cpu_wr_data = 32'h0BAD_BEEF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 no ack", 32'(cpu_wr_ack), 0);
      check("R7 no we", 32'(rf_we), 0);
    end
    read_reg(5'd4, v); check("R7 reg4 untouched", v, 0);
    sclk_idle = 1'b1;
    @(negedge clk);
    check("R7 ack idle", 32'(cpu_wr_ack), 1);
    check("R7 idx", 32'(rf_idx), 4);
    cpu_wr_req = 1'b0;
    read_reg(5'd4, v); check("R7 reg4 written", v, 32'h0BAD_BEEF);

    // R8: serial and internal collide
    send_word(16'h2C81);
    send_word(16'h1111);
    send_word(16'h2222);
    cpu_wr_req  = 1'b1;
    cpu_wr_idx  = 5'd2;
    cpu_wr_data = 32'hCAFE_F00D;
    @(negedge clk);
    check("R8 serial first we", 32'(rf_we), 1);
    check("R8 serial idx", 32'(rf_idx), 1);
    check("R8 cpu waits", 32'(cpu_wr_ack), 0);
    @(negedge clk);
    check("R8 cpu next", 32'(cpu_wr_ack), 1);
    check("R8 cpu idx", 32'(rf_idx), 2);
    check("R8 cpu data", rf_wdata, 32'hCAFE_F00D);
    cpu_wr_req = 1'b0;
    read_reg(5'd1, v); check("R8 reg1", v, 32'h1111_2222);
    read_reg(5'd2, v); check("R8 reg2", v, 32'hCAFE_F00D);

    // R6: internal write to status
    @(negedge clk);
    cpu_wr_req  = 1'b1;
    cpu_wr_idx  = 5'd0;
    cpu_wr_data = 32'h00C0_FFEE;
    @(negedge clk);
    cpu_wr_req = 1'b0;
    @(negedge clk);
    check("R6 status internal", status_reg, 32'h00C0_FFEE);

    // R9: reset mid-sequence
    sclk_idle = 1'b0;
    send_word(16'h2C83);
    send_word(16'h7777);
    do_reset();
    check("R9 reply after reset", 32'(reply_word), 32'(NR));
    check("R9 status cleared", status_reg, 0);
    send_word(16'hBEEF);
    check("R9 restart as command", 32'(reply_word), 32'(ILL));
    read_reg(5'd3, v); check("R9 reg3 cleared", v, 0);
    read_reg(5'd4, v); check("R9 reg4 cleared", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule